// File: doc/BRIEF.md
# Packet-Buffered SPI Master Sequencer

This block sits between a packet-oriented host port and a single SPI slave. The host side writes an outbound packet one byte per cycle into an internal store. A packet ends on its 64th byte or on a byte flagged as the last one. A short packet is sent as a full 64-byte frame with zero bytes in the unused positions. No SPI activity begins until the packet is complete. The block then drives the slave select low and exchanges all 64 bytes full duplex. It sends eight bits per byte, most significant bit first, and leaves a programmable idle stretch between bytes so the slave has time to prepare its next reply.

Each byte clocked in from the slave is stored at the same index as the byte that went out with it. After the last byte the select returns high and the block raises a packet-available flag. The host reads the 64 received bytes back in order. The outbound write port stays closed while a frame is on the wire and while an unread inbound packet is held. Clock polarity, clock phase, the SCLK half-period and the inter-byte gap are runtime inputs. They are sampled while the block is idle and frozen for the duration of a frame.

Top module: `pkt_spi_seq`

## Requirements
- R1: Out of reset, ss_n is 1, sclk is 0, rd_avail is 0 and wr_ready is 1.
- R2: A byte is taken when wr_valid and wr_ready are both 1 on a clock edge. The packet closes on the 64th byte taken or on a byte taken with wr_last = 1. ss_n stays 1 until the packet closes.
- R3: A packet that closes after n < 64 bytes is sent as exactly 64 bytes, with positions n to 63 carrying 0x00.
- R4: ss_n falls on the clock edge that takes the closing byte. The first SCLK edge follows H+1 system cycles later. ss_n rises H cycles after the final SCLK edge of byte 63.
- R5: Every byte is shifted MSB first over 8 SCLK cycles, and transmit and receive happen at once. The byte received during transfer k is returned as the k-th byte read out.
- R6: sclk idles at cfg_cpol. With cfg_cpha = 0, data is sampled on the leading (first) edge of each SCLK cycle and changed on the trailing edge. With cfg_cpha = 1, data is changed on the leading edge and sampled on the trailing edge.
- R7: Each SCLK half-period inside a byte lasts H system cycles, where H = cfg_half, and a cfg_half of 0 acts as 1.
- R8: From the last SCLK edge of one byte to the first SCLK edge of the next there are exactly 2*H + cfg_gap + 2 system cycles.
- R9: rd_avail rises on the same edge that ss_n rises. rd_data shows the byte at the read position, and each cycle with rd_en = 1 advances it. rd_avail falls after the 64th read.
- R10: wr_ready is 0 from the edge that takes the closing byte until the 64th inbound byte has been read. Writes offered while wr_ready is 0 are dropped and start nothing.
- R11: Changes to cfg_cpol, cfg_cpha, cfg_half and cfg_gap while ss_n is 0 have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Outbound byte offered |
| wr_data | input | 8 | Outbound byte |
| wr_last | input | 1 | Offered byte closes the packet |
| wr_ready | output | 1 | Outbound byte can be taken |
| rd_avail | output | 1 | Inbound packet held and unread |
| rd_en | input | 1 | Advance to the next inbound byte |
| rd_data | output | 8 | Inbound byte at the read position |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_half | input | 8 | SCLK half-period in system cycles (0 acts as 1) |
| cfg_gap | input | 16 | Extra idle cycles between bytes |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| ss_n | output | 1 | Active-low slave select |

## Verification
The bench models a slave that samples and drives its data on the edges chosen by the captured clock mode. The slave answers with a per-packet byte pattern that differs from what the master sends, so a swapped, shifted or bit-reversed byte shows up at one end or the other.

The stimulus covers:
- all four clock modes;
- half-periods of 0, 1, 2, 3 and 4;
- gaps from zero upward;
- full packets, plus short packets closed by wr_last at lengths 1, 10 and 33. These separate correct zero padding from stale buffer contents.

The SCLK edge timestamps of every frame are checked against the half-period, gap and select timing rules. One frame rewrites every configuration input mid-frame. Another offers closing writes while the block is busy and holding an unread packet.

// File: rtl/pkt_spi_pkg.sv
package pkt_spi_pkg;

  typedef enum logic [1:0] {
    ST_FILL   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_SHIFT  = 2'd2,
    ST_GAP    = 2'd3
  } seq_state_e;

  // A programmed half-period of zero behaves as one cycle.
  function automatic int unsigned half_cycles(input int unsigned raw);
    return (raw == 0) ? 1 : raw;
  endfunction

  // Sampling happens on the leading edge for phase 0 and on the trailing edge for phase 1.
  function automatic logic is_sample_edge(input logic cpha, input logic leading);
    return leading ^ cpha;
  endfunction

endpackage

// File: rtl/pkt_spi_buf.sv
module pkt_spi_buf #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pkt_spi_shifter.sv
module pkt_spi_shifter #(
  parameter int W     = 8,
  parameter int DIV_W = 8,
  localparam int EDGES = 2 * W,
  localparam int EW    = $clog2(EDGES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [W-1:0]     tx_byte,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIV_W-1:0] half,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             busy,
  output logic             fin,
  output logic [W-1:0]     rx_byte
);
  logic             busy_q, act_q;
  logic [DIV_W-1:0] cnt_q;
  logic [EW-1:0]    edge_q;
  logic [W-1:0]     sh_q, rx_q;
  logic             tick, leading, sample_now, last_seen;

  assign tick       = busy_q && (cnt_q == half - DIV_W'(1));
  assign last_seen  = (edge_q == EW'(EDGES));
  assign leading    = ~edge_q[0];
  assign sample_now = pkt_spi_pkg::is_sample_edge(cpha, leading);
  assign fin        = tick && last_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      act_q  <= 1'b0;
      cnt_q  <= '0;
      edge_q <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      act_q  <= 1'b0;
      cnt_q  <= '0;
      edge_q <= '0;
      sh_q   <= tx_byte;
    end else if (busy_q) begin
      if (!tick) begin
        cnt_q <= cnt_q + DIV_W'(1);
      end else begin
        cnt_q <= '0;
        if (last_seen) begin
          busy_q <= 1'b0;
        end else begin
          act_q  <= ~act_q;
          edge_q <= edge_q + EW'(1);
          if (sample_now) rx_q <= {rx_q[W-2:0], miso};
          else if (!(cpha && edge_q == '0)) sh_q <= {sh_q[W-2:0], 1'b0};
        end
      end
    end
  end

  assign sclk    = cpol ^ act_q;
  assign mosi    = sh_q[W-1];
  assign busy    = busy_q;
  assign rx_byte = rx_q;
endmodule

// File: rtl/pkt_spi_seq.sv
module pkt_spi_seq #(
  parameter int PKT_LEN = 64,
  parameter int W       = 8,
  parameter int DIV_W   = 8,
  parameter int GAP_W   = 16,
  localparam int IDX_W  = $clog2(PKT_LEN),
  localparam int LEN_W  = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [W-1:0]     wr_data,
  input  logic             wr_last,
  output logic             wr_ready,
  output logic             rd_avail,
  input  logic             rd_en,
  output logic [W-1:0]     rd_data,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic [DIV_W-1:0] cfg_half,
  input  logic [GAP_W-1:0] cfg_gap,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             ss_n
);
  import pkt_spi_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_LEN - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] wr_idx_q, k_q, rd_ptr_q;
  logic [LEN_W-1:0] len_q;
  logic [GAP_W-1:0] gcnt_q, gap_q;
  logic [DIV_W-1:0] half_q, half_eff;
  logic             cpol_q, cpha_q, ss_q, rx_full_q;

  logic             wr_fire, wr_final, rd_pop, eng_start;
  logic             eng_busy, eng_fin, pkt_done;
  logic [W-1:0]     tx_rdata, tx_byte, eng_rx;

  assign wr_ready  = (state_q == ST_FILL) && !rx_full_q;
  assign wr_fire   = wr_valid && wr_ready;
  assign wr_final  = wr_fire && (wr_last || wr_idx_q == LAST);
  assign rd_pop    = rd_en && rx_full_q;
  assign eng_start = (state_q == ST_LAUNCH);
  assign pkt_done  = eng_fin && (k_q == LAST);
  assign half_eff  = DIV_W'(half_cycles(32'(half_q)));
  assign tx_byte   = (LEN_W'(k_q) < len_q) ? tx_rdata : '0;

  pkt_spi_buf #(.DEPTH(PKT_LEN), .W(W)) u_txbuf (
    .clk(clk), .we(wr_fire), .waddr(wr_idx_q), .wdata(wr_data),
    .raddr(k_q), .rdata(tx_rdata)
  );

  pkt_spi_buf #(.DEPTH(PKT_LEN), .W(W)) u_rxbuf (
    .clk(clk), .we(eng_fin), .waddr(k_q), .wdata(eng_rx),
    .raddr(rd_ptr_q), .rdata(rd_data)
  );

  pkt_spi_shifter #(.W(W), .DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .tx_byte(tx_byte),
    .cpol(cpol_q), .cpha(cpha_q), .half(half_eff), .miso(miso),
    .sclk(sclk), .mosi(mosi), .busy(eng_busy), .fin(eng_fin), .rx_byte(eng_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_FILL;
      wr_idx_q  <= '0;
      k_q       <= '0;
      rd_ptr_q  <= '0;
      len_q     <= '0;
      gcnt_q    <= '0;
      gap_q     <= '0;
      half_q    <= '0;
      cpol_q    <= 1'b0;
      cpha_q    <= 1'b0;
      ss_q      <= 1'b1;
      rx_full_q <= 1'b0;
    end else begin
      if (rd_pop) begin
        if (rd_ptr_q == LAST) begin
          rd_ptr_q  <= '0;
          rx_full_q <= 1'b0;
        end else begin
          rd_ptr_q <= rd_ptr_q + IDX_W'(1);
        end
      end
      case (state_q)
        ST_FILL: begin
          cpol_q <= cfg_cpol;
          cpha_q <= cfg_cpha;
          half_q <= cfg_half;
          gap_q  <= cfg_gap;
          if (wr_final) begin
            wr_idx_q <= '0;
            len_q    <= LEN_W'(wr_idx_q) + LEN_W'(1);
            k_q      <= '0;
            ss_q     <= 1'b0;
            state_q  <= ST_LAUNCH;
          end else if (wr_fire) begin
            wr_idx_q <= wr_idx_q + IDX_W'(1);
          end
        end
        ST_LAUNCH: state_q <= ST_SHIFT;
        ST_SHIFT: begin
          if (pkt_done) begin
            ss_q      <= 1'b1;
            rx_full_q <= 1'b1;
            k_q       <= '0;
            state_q   <= ST_FILL;
          end else if (eng_fin) begin
            k_q     <= k_q + IDX_W'(1);
            gcnt_q  <= '0;
            state_q <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gcnt_q == gap_q) state_q <= ST_LAUNCH;
          else gcnt_q <= gcnt_q + GAP_W'(1);
        end
        default: state_q <= ST_FILL;
      endcase
    end
  end

  assign ss_n     = ss_q;
  assign rd_avail = rx_full_q;
endmodule

// File: rtl/pkt_spi_seq_chk.sv
module pkt_spi_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ss_n,
  input logic sclk,
  input logic wr_ready,
  input logic rd_avail,
  input logic rd_en,
  input logic eng_busy,
  input logic pkt_done
);
  // R10: the write port opens only with the select released and nothing held.
  a_r10_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (ss_n && !rd_avail));

  // R4: the shifter runs only inside a selected frame.
  a_r4_busy_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !ss_n);

  // R9: the select is released together with the packet hand-off.
  a_r9_release_with_avail: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n) |-> (rd_avail && $past(pkt_done)));

  // R9: the held packet is dropped only by a read.
  a_r9_drop_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_avail) |-> $past(rd_en));

  // R6: inside a frame SCLK moves only while a byte is shifting.
  a_r6_sclk_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_n && $past(!ss_n) && !$stable(sclk)) |-> $past(eng_busy));
endmodule

bind pkt_spi_seq pkt_spi_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sclk(sclk), .wr_ready(wr_ready),
  .rd_avail(rd_avail), .rd_en(rd_en), .eng_busy(eng_busy), .pkt_done(pkt_done)
);

// File: tb/pkt_spi_seq_bench.sv
module pkt_spi_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_last = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [7:0] cfg_half = 8'd1;
  logic [15:0] cfg_gap = '0;
  logic miso = 1'b0;
  logic wr_ready, rd_avail, sclk, mosi, ss_n;
  logic [7:0] rd_data;

  int vectors = 0, fails = 0, cyc = 0, pkt_no = 0;
  bit exp_busy = 0;

  // slave model state
  int edges[$];
  int fall_cyc = 0, rise_cyc = 0, bidx = 0, bitn = 0;
  logic fr_cpol = 1'b0, fr_cpha = 1'b0;
  logic [7:0] rsh = '0;
  logic [7:0] slv_rx [64];

  always #5 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  pkt_spi_seq u_pkt_spi_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_last(wr_last), .wr_ready(wr_ready), .rd_avail(rd_avail), .rd_en(rd_en),
    .rd_data(rd_data), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_half(cfg_half), .cfg_gap(cfg_gap), .sclk(sclk), .mosi(mosi),
    .miso(miso), .ss_n(ss_n)
  );

  function automatic logic [7:0] resp(input int p, input int k);
    return 8'((k * 37 + p * 11 + 90) & 255);
  endfunction

  function automatic logic [7:0] txv(input int p, input int k);
    return 8'(((k * 13 + p * 29 + 7) ^ 8'h3C) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Slave side of the link.
  always @(negedge ss_n) begin
    if (rst_n) begin
      logic [7:0] t;
      edges.delete();
      fall_cyc = cyc;
      bidx = 0;
      bitn = 0;
      fr_cpol = cfg_cpol;
      fr_cpha = cfg_cpha;
      t = resp(pkt_no, 0);
      miso = t[7];
    end
  end

  always @(posedge ss_n) begin
    if (rst_n) begin
      rise_cyc = cyc;
      pkt_no++;
    end
  end

  always @(sclk) begin
    if (rst_n && ss_n === 1'b0) begin
      logic lead;
      logic [7:0] t;
      edges.push_back(cyc);
      lead = (sclk != fr_cpol);
      if (lead ^ fr_cpha) begin
        rsh = {rsh[6:0], mosi};
        bitn++;
        if (bitn == 8) begin
          if (bidx < 64) slv_rx[bidx] = rsh;
          bidx++;
          bitn = 0;
        end
      end else begin
        t = resp(pkt_no, bidx);
        miso = t[7 - bitn];
      end
    end
  end

  // Per-clock comparison against the bench's own view of the block.
  logic prev_ss = 1'b1, prev_cpol = 1'b0;
  always begin
    @(posedge clk);
    #2;
    if (rst_n) begin
      chk(wr_ready == !exp_busy, "R10 wr_ready", int'(wr_ready), int'(!exp_busy));
      if (!exp_busy) chk(ss_n == 1'b1, "R2 select idle", int'(ss_n), 1);
      if (ss_n && prev_ss && cfg_cpol == prev_cpol)
        chk(sclk == cfg_cpol, "R6 idle level", int'(sclk), int'(cfg_cpol));
      prev_ss = ss_n;
      prev_cpol = cfg_cpol;
    end
  end

  task automatic run_packet(input int n, input bit cp, input bit ch, input int half,
                            input int gap, input bit junk, input bit midchg);
    logic [7:0] exp_tx [64];
    int h, p, t, bad7, bad8, a7, a8;
    h = (half == 0) ? 1 : half;
    p = pkt_no;
    @(negedge clk);
    cfg_cpol = cp; cfg_cpha = ch; cfg_half = 8'(half); cfg_gap = 16'(gap);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 64; i++) exp_tx[i] = (i < n) ? txv(p, i) : 8'h00;
    for (int i = 0; i < n; i++) begin
      chk(wr_ready == 1'b1, "R2 ready during fill", int'(wr_ready), 1);
      chk(ss_n == 1'b1, "R2 no select before close", int'(ss_n), 1);
      wr_valid = 1'b1; wr_data = txv(p, i); wr_last = (i == n - 1);
      @(posedge clk);
      if (i == n - 1) exp_busy = 1;
      @(negedge clk);
    end
    wr_valid = 1'b0; wr_last = 1'b0;
    if (midchg) begin  // R11
      cfg_cpol = !cp; cfg_cpha = !ch; cfg_half = 8'(half + 3); cfg_gap = 16'(gap + 7);
    end
    if (junk) begin  // R10 refused writes
      wr_valid = 1'b1; wr_data = 8'hEE; wr_last = 1'b1;
    end
    t = 0;
    while (!rd_avail && t < 40000) begin @(negedge clk); t++; end
    chk(rd_avail == 1'b1, "R9 packet available", int'(rd_avail), 1);
    if (junk) begin
      repeat (10) begin
        @(negedge clk);
        chk(ss_n == 1'b1, "R10 refused write starts nothing", int'(ss_n), 1);
      end
      wr_valid = 1'b0; wr_last = 1'b0;
    end
    // frame timing
    chk(edges.size() == 1024, "R7 edge count", edges.size(), 1024);
    if (edges.size() == 1024) begin
      chk(edges[0] - fall_cyc == h + 1, "R4 select to first edge", edges[0] - fall_cyc, h + 1);
      chk(rise_cyc - edges[1023] == h, "R4 last edge to release", rise_cyc - edges[1023], h);
      bad7 = 0; bad8 = 0; a7 = h; a8 = 2 * h + gap + 2;
      for (int j = 1; j < 1024; j++) begin
        if (j % 16 != 0) begin
          if (edges[j] - edges[j-1] != h) begin bad7++; a7 = edges[j] - edges[j-1]; end
        end else begin
          if (edges[j] - edges[j-1] != 2 * h + gap + 2) begin bad8++; a8 = edges[j] - edges[j-1]; end
        end
      end
      chk(bad7 == 0, "R7 half-period", a7, h);
      chk(bad8 == 0, "R8 inter-byte gap", a8, 2 * h + gap + 2);
    end
    chk(bidx == 64, "R3 frame length", bidx, 64);
    for (int i = 0; i < 64; i++)
      chk(slv_rx[i] == exp_tx[i], (i < n) ? "R5/R6 byte at slave" : "R3 zero pad",
          int'(slv_rx[i]), int'(exp_tx[i]));
    // read back
    for (int k = 0; k < 64; k++) begin
      chk(rd_avail == 1'b1, "R9 avail while reading", int'(rd_avail), 1);
      chk(rd_data == resp(p, k), "R5/R6 inbound byte", int'(rd_data), int'(resp(p, k)));
      rd_en = 1'b1;
      @(posedge clk);
      if (k == 63) exp_busy = 0;
      @(negedge clk);
    end
    rd_en = 1'b0;
    chk(rd_avail == 1'b0, "R9 avail drops after last read", int'(rd_avail), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ss_n == 1'b1, "R1 select", int'(ss_n), 1);
    chk(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
    chk(rd_avail == 1'b0, "R1 avail", int'(rd_avail), 0);
    chk(wr_ready == 1'b1, "R1 ready", int'(wr_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_packet(64, 0, 0, 2, 3, 0, 0);
    run_packet(64, 0, 1, 1, 0, 0, 0);
    run_packet(10, 1, 0, 3, 5, 0, 0);
    run_packet(1,  1, 1, 0, 1, 1, 0);
    run_packet(64, 0, 0, 4, 2, 0, 1);
    run_packet(33, 1, 1, 2, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=finish", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule